// File: doc/BRIEF.md
# Virtual Interrupt Flag Controller

This block settles the effect of an interrupt-disable (CLI) or interrupt-enable (STI) instruction on the processor's interrupt flag (IF), virtual interrupt flag (VIF) and virtual-interrupt-pending flag (VIP). When the instruction strobe is high, the block reads the enable bit for protected-mode virtual interrupts, the current privilege level and the I/O privilege level. From these it picks one of three outcomes: the instruction changes VIF, the instruction changes IF, or it raises a general-protection fault. The resulting flags and a one-cycle fault strobe are registered.

Virtual handling is in force only when three things hold together: the enable bit is 1, the current privilege level is 3, and the I/O privilege level is below 3. In that case CLI and STI act on VIF. An STI issued while VIP is set faults, so that the pending interrupt can be serviced. In every other case the legacy rule applies. A caller that is less privileged than the I/O privilege level faults. Any other caller writes IF.

The block also sorts incoming interrupt requests by vector number. Vectors below 32 (NMI and exceptions) are always handled the normal way. Maskable vectors go to the virtual mechanism only while virtual handling is in force. Instructions such as flag push/pop, interrupt return and software interrupt never raise the strobe, so this block leaves them untouched.

Top module: `vif_flag_ctrl`

## Requirements
- R1: While rst_n is low at a rising edge, flag_if, flag_vif, flag_vip and gp_fault are all 0 after that edge.
- R2: In virtual mode (virt_en=1, cpl=3, iopl<3), a strobed CLI (op_sti=0) registers flag_vif=0, flag_if=cur_if and flag_vip=cur_vip.
- R3: In virtual mode, a strobed STI (op_sti=1) with cur_vip=0 registers flag_vif=1, flag_if=cur_if and flag_vip=0, with no fault.
- R4: In virtual mode, a strobed STI with cur_vip=1 raises gp_fault, and the flags register cur_if, cur_vif and cur_vip unchanged.
- R5: Outside virtual mode, a strobed CLI or STI with cpl numerically greater than iopl raises gp_fault, and the flags register the cur_* values unchanged.
- R6: Outside virtual mode, with cpl at or below iopl, a strobed CLI registers flag_if=0 and a strobed STI registers flag_if=1. flag_vif and flag_vip take cur_vif and cur_vip.
- R7: gp_fault is high for exactly the one cycle after the faulting strobe edge, and is low in the cycle that follows.
- R8: At an edge where instr_valid=0, the flag outputs keep their values and gp_fault is 0, whatever the other inputs are.
- R9: For irq_vector below 32, irq_normal equals irq_valid and irq_virt is 0, whatever the mode.
- R10: For irq_vector of 32 or above with irq_valid=1, irq_virt is 1 in virtual mode and irq_normal is 1 otherwise. Never are both high, and neither is high when irq_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Strobe: a CLI or STI executes this cycle |
| op_sti | input | 1 | Instruction type: 1 = STI, 0 = CLI |
| virt_en | input | 1 | Enable for protected-mode virtual interrupts |
| cpl | input | 2 | Current privilege level |
| iopl | input | 2 | I/O privilege level |
| cur_if | input | 1 | Current IF value |
| cur_vif | input | 1 | Current VIF value |
| cur_vip | input | 1 | Current VIP value |
| irq_valid | input | 1 | Interrupt request present |
| irq_vector | input | 8 | Vector number of the request |
| flag_if | output | 1 | Registered next IF |
| flag_vif | output | 1 | Registered next VIF |
| flag_vip | output | 1 | Registered next VIP |
| gp_fault | output | 1 | One-cycle general-protection fault strobe |
| irq_normal | output | 1 | Request must take the normal path |
| irq_virt | output | 1 | Request goes to the virtual mechanism |

## Verification
The instruction path is driven over every combination of enable bit, both privilege levels, VIP and instruction type, and each result is checked against a model in the bench. This sweep tells the three paths apart. It also shows where the legacy privilege comparison diverges from the virtual-mode condition, for example cpl=3 with iopl=3, or cpl below 3 with the enable bit set. Idle cycles with scrambled inputs show that the registers hold and the strobe stays low. Requests at vectors 0, 31, 32 and 255 are checked under both modes, and with no request present, to catch an off-by-one at the maskable boundary.

// File: rtl/vif_pkg.sv
// Package vif_pkg: shared types for the virtual interrupt flag controller.
// Assumes: flag order in flags_t is IF, VIF, VIP from MSB to LSB.
package vif_pkg;
    typedef enum logic [1:0] {
        PATH_VIRT   = 2'd0,
        PATH_LEGACY = 2'd1,
        PATH_FAULT  = 2'd2
    } path_e;

    typedef struct packed {
        logic if_f;
        logic vif_f;
        logic vip_f;
    } flags_t;
endpackage

// File: rtl/vif_mode_detect.sv
// Module vif_mode_detect: decides whether virtual interrupt handling is in force.
// Assumes: the least privileged level is the all-ones code of PL_W bits.
module vif_mode_detect #(
    parameter int PL_W = 2
) (
    input  logic            virt_en,
    input  logic [PL_W-1:0] cpl,
    input  logic [PL_W-1:0] iopl,
    output logic            virt_active
);
    localparam logic [PL_W-1:0] LEAST_PRIV = '1;

    // Purpose: virtual mode needs enable, least-privileged caller, iopl below top.
    always_comb begin
        virt_active = virt_en && (cpl == LEAST_PRIV) && (iopl != LEAST_PRIV);
    end
endmodule

// File: rtl/vif_path_select.sv
// Module vif_path_select: picks the outcome of CLI/STI and forms the next flags.
// Assumes: inputs are stable while instr_valid is high; a fault leaves flags as given.
module vif_path_select
    import vif_pkg::*;
#(
    parameter int PL_W = 2
) (
    input  logic            virt_active,
    input  logic            op_sti,
    input  logic [PL_W-1:0] cpl,
    input  logic [PL_W-1:0] iopl,
    input  flags_t          cur_flags,
    output path_e           path,
    output flags_t          next_flags,
    output logic            fault
);
    // Purpose: choose virtual, legacy or fault path by mode, privilege and VIP.
    always_comb begin
        if (virt_active) begin
            path = (op_sti && cur_flags.vip_f) ? PATH_FAULT : PATH_VIRT;
        end else begin
            path = (cpl > iopl) ? PATH_FAULT : PATH_LEGACY;
        end
    end

    // Purpose: build next flags; only one flag moves on a non-fault path.
    always_comb begin
        next_flags = cur_flags;
        fault      = 1'b0;
        unique case (path)
            PATH_VIRT:   next_flags.vif_f = op_sti;
            PATH_LEGACY: next_flags.if_f  = op_sti;
            PATH_FAULT:  fault            = 1'b1;
            default:     fault            = 1'b0;
        endcase
    end
endmodule

// File: rtl/vif_irq_gate.sv
// Module vif_irq_gate: routes a request to the normal or virtual handling path.
// Assumes: vectors below MASK_BASE are NMI/exceptions and never virtualised.
module vif_irq_gate #(
    parameter int VEC_W     = 8,
    parameter int MASK_BASE = 32
) (
    input  logic             irq_valid,
    input  logic [VEC_W-1:0] irq_vector,
    input  logic             virt_active,
    output logic             irq_normal,
    output logic             irq_virt
);
    localparam logic [VEC_W-1:0] BASE_V = VEC_W'(MASK_BASE);

    logic maskable;

    generate
        if (MASK_BASE == 0) begin : g_all_maskable
            // Purpose: every vector is maskable when the base is zero.
            always_comb maskable = 1'b1;
        end else begin : g_split
            // Purpose: compare the vector against the first maskable number.
            always_comb maskable = (irq_vector >= BASE_V);
        end
    endgenerate

    // Purpose: send maskable requests to the virtual path only in virtual mode.
    always_comb begin
        irq_virt   = irq_valid && maskable && virt_active;
        irq_normal = irq_valid && !(maskable && virt_active);
    end
endmodule

// File: rtl/vif_flag_ctrl.sv
// Module vif_flag_ctrl: top of the virtual interrupt flag controller.
// Registers the flags produced by a strobed CLI/STI and a one-cycle fault strobe,
// and routes interrupt requests combinationally.
// Assumes: synchronous active-low reset; with no strobe the registers hold.
module vif_flag_ctrl
    import vif_pkg::*;
#(
    parameter int PL_W      = 2,
    parameter int VEC_W     = 8,
    parameter int MASK_BASE = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_valid,
    input  logic             op_sti,
    input  logic             virt_en,
    input  logic [PL_W-1:0]  cpl,
    input  logic [PL_W-1:0]  iopl,
    input  logic             cur_if,
    input  logic             cur_vif,
    input  logic             cur_vip,
    input  logic             irq_valid,
    input  logic [VEC_W-1:0] irq_vector,
    output logic             flag_if,
    output logic             flag_vif,
    output logic             flag_vip,
    output logic             gp_fault,
    output logic             irq_normal,
    output logic             irq_virt
);
    logic   virt_active;
    path_e  path;
    flags_t cur_flags;
    flags_t next_flags;
    flags_t flags_q;
    logic   fault_c;
    logic   fault_q;

    // Purpose: pack the incoming flag values into the shared struct.
    always_comb cur_flags = '{if_f: cur_if, vif_f: cur_vif, vip_f: cur_vip};

    vif_mode_detect #(.PL_W(PL_W)) mode_i (
        .virt_en    (virt_en),
        .cpl        (cpl),
        .iopl       (iopl),
        .virt_active(virt_active)
    );

    vif_path_select #(.PL_W(PL_W)) sel_i (
        .virt_active(virt_active),
        .op_sti     (op_sti),
        .cpl        (cpl),
        .iopl       (iopl),
        .cur_flags  (cur_flags),
        .path       (path),
        .next_flags (next_flags),
        .fault      (fault_c)
    );

    vif_irq_gate #(.VEC_W(VEC_W), .MASK_BASE(MASK_BASE)) gate_i (
        .irq_valid  (irq_valid),
        .irq_vector (irq_vector),
        .virt_active(virt_active),
        .irq_normal (irq_normal),
        .irq_virt   (irq_virt)
    );

    // Purpose: capture flags on a strobe; the fault strobe lasts one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            fault_q <= 1'b0;
        end else begin
            fault_q <= instr_valid && fault_c;
            if (instr_valid) begin
                flags_q <= next_flags;
            end
        end
    end

    // Purpose: drive the flag outputs from the register.
    always_comb begin
        flag_if  = flags_q.if_f;
        flag_vif = flags_q.vif_f;
        flag_vip = flags_q.vip_f;
        gp_fault = fault_q;
    end
endmodule

// Module vif_flag_ctrl_chk: port-level properties of vif_flag_ctrl.
// Assumes: bound to every instance; properties are disabled during reset.
module vif_flag_ctrl_chk #(
    parameter int PL_W  = 2,
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             instr_valid,
    input logic             op_sti,
    input logic             virt_en,
    input logic [PL_W-1:0]  cpl,
    input logic [PL_W-1:0]  iopl,
    input logic             cur_if,
    input logic             cur_vif,
    input logic             cur_vip,
    input logic             irq_valid,
    input logic [VEC_W-1:0] irq_vector,
    input logic             flag_if,
    input logic             flag_vif,
    input logic             flag_vip,
    input logic             gp_fault,
    input logic             irq_normal,
    input logic             irq_virt
);
    localparam logic [PL_W-1:0]  TOP_PL = '1;
    localparam logic [VEC_W-1:0] FIRST_MASKABLE = VEC_W'(32);

    logic in_virt;
    always_comb in_virt = virt_en && (cpl == TOP_PL) && (iopl != TOP_PL);

    assert_virt_if_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && in_virt |=> flag_if == $past(cur_if));

    assert_virt_sti_R3: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && in_virt && op_sti && !cur_vip |=> flag_vif && !gp_fault);

    assert_fault_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid |=> !gp_fault || ({flag_if, flag_vif, flag_vip} ==
                        {$past(cur_if), $past(cur_vif), $past(cur_vip)}));

    assert_legacy_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && !in_virt && (cpl > iopl) |=> gp_fault);

    assert_legacy_vflags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && !in_virt |=> flag_vif == $past(cur_vif) && flag_vip == $past(cur_vip));

    assert_fault_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        gp_fault && !instr_valid |=> !gp_fault);

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> $stable({flag_if, flag_vif, flag_vip}) && !gp_fault);

    assert_exc_normal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid && (irq_vector < FIRST_MASKABLE) |-> irq_normal && !irq_virt);

    assert_route_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({irq_normal, irq_virt}) == (irq_valid ? 1 : 0));
endmodule

bind vif_flag_ctrl vif_flag_ctrl_chk #(.PL_W(PL_W), .VEC_W(VEC_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr_valid(instr_valid),
    .op_sti     (op_sti),
    .virt_en    (virt_en),
    .cpl        (cpl),
    .iopl       (iopl),
    .cur_if     (cur_if),
    .cur_vif    (cur_vif),
    .cur_vip    (cur_vip),
    .irq_valid  (irq_valid),
    .irq_vector (irq_vector),
    .flag_if    (flag_if),
    .flag_vif   (flag_vif),
    .flag_vip   (flag_vip),
    .gp_fault   (gp_fault),
    .irq_normal (irq_normal),
    .irq_virt   (irq_virt)
);

// File: tb/vif_flag_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench vif_flag_ctrl_tb_top: scoreboard bench; driver tasks queue expected
// results, a negedge monitor pops and compares them.
module vif_flag_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       instr_valid = 1'b0;
    logic       op_sti = 1'b0;
    logic       virt_en = 1'b0;
    logic [1:0] cpl = 2'd0;
    logic [1:0] iopl = 2'd0;
    logic       cur_if = 1'b0;
    logic       cur_vif = 1'b0;
    logic       cur_vip = 1'b0;
    logic       irq_valid = 1'b0;
    logic [7:0] irq_vector = 8'd0;
    logic       flag_if, flag_vif, flag_vip, gp_fault, irq_normal, irq_virt;

    typedef struct {
        logic  e_if;
        logic  e_vif;
        logic  e_vip;
        logic  e_flt;
        string req;
    } exp_t;

    exp_t sb_q[$];
    exp_t mon_item;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 0;
    logic m_if = 1'b0, m_vif = 1'b0, m_vip = 1'b0;

    always #2 clk = ~clk;

    vif_flag_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .op_sti(op_sti),
        .virt_en(virt_en), .cpl(cpl), .iopl(iopl), .cur_if(cur_if),
        .cur_vif(cur_vif), .cur_vip(cur_vip), .irq_valid(irq_valid),
        .irq_vector(irq_vector), .flag_if(flag_if), .flag_vif(flag_vif),
        .flag_vip(flag_vip), .gp_fault(gp_fault), .irq_normal(irq_normal),
        .irq_virt(irq_virt)
    );

    task automatic check1(string req, string what, logic [3:0] act, logic [3:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // Monitor: pop one expected item per cycle and compare registered outputs.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            mon_item = sb_q.pop_front();
            check1(mon_item.req, "flags{if,vif,vip}",
                   {1'b0, flag_if, flag_vif, flag_vip},
                   {1'b0, mon_item.e_if, mon_item.e_vif, mon_item.e_vip});
            check1(mon_item.req, "gp_fault", {3'b0, gp_fault}, {3'b0, mon_item.e_flt});
        end
    end

    task automatic push_exp(logic flt, string req);
        exp_t e;
        e.e_if = m_if; e.e_vif = m_vif; e.e_vip = m_vip; e.e_flt = flt; e.req = req;
        sb_q.push_back(e);
    endtask

    // Driver: one strobed CLI/STI, result check, then one quiet-cycle check.
    task automatic run_instr(bit en, int c, int io, bit op, bit cif, bit cvif, bit cvip);
        bit    va;
        bit    flt;
        string rq;
        @(posedge clk); #1;
        virt_en = en; cpl = 2'(c); iopl = 2'(io); op_sti = op;
        cur_if = cif; cur_vif = cvif; cur_vip = cvip; instr_valid = 1'b1;
        va = en && (c == 3) && (io != 3);
        if (va) begin
            flt = op && cvip;
            rq  = flt ? "R4" : (op ? "R3" : "R2");
        end else begin
            flt = (c > io);
            rq  = flt ? "R5" : "R6";
        end
        m_if = cif; m_vif = cvif; m_vip = cvip;
        if (!flt) begin
            if (va) m_vif = op;
            else    m_if  = op;
        end
        @(posedge clk); #1;
        instr_valid = 1'b0;
        push_exp(flt, rq);
        @(posedge clk); #1;
        push_exp(1'b0, "R7");
    endtask

    // Driver: no strobe, inputs scrambled; registers must hold (R8).
    task automatic idle_scramble(bit en, int c, int io);
        @(posedge clk); #1;
        instr_valid = 1'b0; virt_en = en; cpl = 2'(c); iopl = 2'(io);
        op_sti = ~op_sti; cur_if = ~m_if; cur_vif = ~m_vif; cur_vip = ~m_vip;
        @(posedge clk); #1;
        push_exp(1'b0, "R8");
    endtask

    // Direct check of the combinational request routing (R9, R10).
    task automatic irq_chk(bit en, int c, int io, int vec, bit v);
        bit va;
        bit e_norm;
        bit e_virt;
        @(posedge clk); #1;
        virt_en = en; cpl = 2'(c); iopl = 2'(io);
        irq_vector = 8'(vec); irq_valid = v;
        #1;
        va     = en && (c == 3) && (io != 3);
        e_virt = v && (vec >= 32) && va;
        e_norm = v && !((vec >= 32) && va);
        check1((vec < 32) ? "R9" : "R10", "irq{normal,virt}",
               {2'b0, irq_normal, irq_virt}, {2'b0, e_norm, e_virt});
        irq_valid = 1'b0;
    endtask

    initial begin
        // R1: reset with a strobe and all-ones inputs still yields zeros.
        instr_valid = 1'b1; op_sti = 1'b1; cur_if = 1'b1; cur_vif = 1'b1; cur_vip = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        instr_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check1("R1", "outputs after reset",
               {flag_if, flag_vif, flag_vip, gp_fault}, 4'b0000);

        // Full sweep: enable, cpl, iopl, VIP and instruction type.
        for (int e = 0; e < 2; e++)
            for (int c = 0; c < 4; c++)
                for (int io = 0; io < 4; io++)
                    for (int vp = 0; vp < 2; vp++)
                        for (int o = 0; o < 2; o++)
                            run_instr(e[0], c, io, o[0], c[0] ^ o[0], io[0] ^ e[0], vp[0]);

        // R8: quiet cycles under several input patterns.
        idle_scramble(1'b1, 3, 0);
        idle_scramble(1'b0, 0, 3);
        idle_scramble(1'b1, 3, 3);

        // R9/R10: boundary vectors under both modes and with no request.
        for (int m = 0; m < 3; m++) begin
            irq_chk(m == 0, (m == 1) ? 0 : 3, (m == 2) ? 3 : 1, 0, 1'b1);
            irq_chk(m == 0, (m == 1) ? 0 : 3, (m == 2) ? 3 : 1, 31, 1'b1);
            irq_chk(m == 0, (m == 1) ? 0 : 3, (m == 2) ? 3 : 1, 32, 1'b1);
            irq_chk(m == 0, (m == 1) ? 0 : 3, (m == 2) ? 3 : 1, 255, 1'b1);
            irq_chk(m == 0, (m == 1) ? 0 : 3, (m == 2) ? 3 : 1, 200, 1'b0);
        end

        // R1 again: reset after flags were set clears them.
        run_instr(1'b0, 0, 0, 1'b1, 1'b1, 1'b1, 1'b1);
        @(posedge clk); #1;
        rst_n = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        check1("R1", "outputs after second reset",
               {flag_if, flag_vif, flag_vip, gp_fault}, 4'b0000);

        repeat (3) @(posedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(4 * 150000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule